// File: doc/BRIEF.md
# BCD Alarm Comparator with Repeat Rates

This block watches a running calendar time and raises an alarm when that time matches a programmed setting. The time arrives as five BCD fields (month, day of month, hour, minute, second), together with a strobe that pulses once per second when the fields take a new value. Five alarm bytes hold the BCD setting. Five rate bits are spread across those bytes and select which fields take part in the comparison, from no field at all (an alarm every second) to all five (an alarm once a year). A rate code that is not one of the six defined codes is treated as the every-second rate.

A match sets a sticky alarm flag. It also drives an active-low interrupt request, modelled as an open-drain pull-down enable, when the interrupt enable bit is set. While the backup-mode indicator is high, the backup enable bit must be set as well. Reading the flags register releases the request and clears the flag. A power-up event clears both enable bits, so an alarm that arrives during power-up only leaves the flag set for the host to find.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, alarm_flag is 0, irq_pull is 0 and irq_n is 1. All alarm bytes are zero, which selects the yearly rate with both enables cleared.
- R2: Alarm bytes are written through wr_sel, where 0 is seconds, 1 is minutes, 2 is hours, 3 is day and 4 is month. Rate bits 1 to 4 sit in bit 7 of selects 0 to 3, and rate bit 5 sits in bit 6 of select 3. The interrupt enable is bit 7 and the backup enable is bit 5 of select 4. The BCD values occupy the low 7, 7, 6, 6 and 5 bits. The rate code {bit5..bit1} = 11111 gives an event on every strobe.
- R3: Code 11110 gives an event only when the seconds match.
- R4: Code 11100 requires seconds and minutes to match. Code 11000 also requires the hour to match.
- R5: Code 10000 also requires the day to match. Code 00000 requires all five fields, month included, to match.
- R6: Any other rate code gives an event on every strobe.
- R7: Matching is evaluated only on a strobe. An event sets alarm_flag at the clock edge that samples the strobe, and a matching time without a strobe sets nothing.
- R8: Outside backup mode, an event asserts irq_pull (irq_n low) only when the interrupt enable is 1. The flag is set either way.
- R9: In backup mode, an event asserts irq_pull only when both enables are 1.
- R10: A flags read (flag_rd) clears alarm_flag and releases irq_pull at the next edge. An event in the same cycle takes priority and leaves both set.
- R11: pwr_up clears both enable bits and leaves the rest of the month byte unchanged. It also overrides a write to the month byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe marking a new second |
| cur_month | input | 8 | Current month, BCD |
| cur_day | input | 8 | Current day of month, BCD |
| cur_hour | input | 8 | Current hour, BCD, 24-hour |
| cur_min | input | 8 | Current minute, BCD |
| cur_sec | input | 8 | Current second, BCD |
| wr_en | input | 1 | Alarm byte write strobe |
| wr_sel | input | 3 | Alarm byte select, 0 to 4 |
| wr_data | input | 8 | Alarm byte write data |
| flag_rd | input | 1 | Flags register read strobe |
| backup | input | 1 | Backup-mode indicator |
| pwr_up | input | 1 | Power-up event pulse |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_pull | output | 1 | Open-drain enable: 1 pulls the request line low |
| irq_n | output | 1 | Active-low interrupt request level |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a flags read and a matching strobe. The bench pulses flag_rd together with a strobe under the every-second rate and expects the flag and the request to survive. It then issues a lone read and expects both to drop. The second pair is a power-up event and a month-byte write that sets both enables. The bench applies them together and judges the result by the next event: the flag must be set while irq_n stays high.

// File: rtl/alarm_pkg.sv
// Package: shared field indices, widths and the rate encoding for the alarm comparator.
// Assumes five BCD fields, each carried in one byte.
package alarm_pkg;
    localparam int BYTE_W  = 8;
    localparam int NFIELD  = 5;
    localparam int SEL_W   = 3;
    localparam int BUS_W   = BYTE_W * NFIELD;

    // field indices; the order is also the wr_sel encoding
    localparam int F_SEC   = 0;
    localparam int F_MIN   = 1;
    localparam int F_HOUR  = 2;
    localparam int F_DAY   = 3;
    localparam int F_MONTH = 4;

    // significant BCD bits of each field, month in the top byte
    localparam logic [BUS_W-1:0] FIELD_MASKS = {8'h1F, 8'h3F, 8'h3F, 8'h7F, 8'h7F};

    typedef enum logic [2:0] {
        RATE_SEC, RATE_MIN, RATE_HOUR, RATE_DAY, RATE_MONTH, RATE_YEAR
    } rate_e;
endpackage

// File: rtl/alarm_bytes.sv
// Module: storage for the five alarm bytes.
// A power-up event clears the two enable bits of the month byte.
// Assumes wr_sel values above 4 are not mapped and are ignored.
module alarm_bytes
    import alarm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic                 pwr_up,
    output logic [BUS_W-1:0]     bytes_q
);
    localparam int IE_BIT = 7;
    localparam int BE_BIT = 5;

    genvar g;
    generate
        for (g = 0; g < NFIELD; g++) begin : g_byte
            logic [BYTE_W-1:0] q;
            // hold one alarm byte; a power-up event overrides a same-cycle write on the enables
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else begin
                    if (wr_en && (wr_sel == SEL_W'(g))) q <= wr_data;
                    if (pwr_up && (g == F_MONTH)) begin
                        q[IE_BIT] <= 1'b0;
                        q[BE_BIT] <= 1'b0;
                    end
                end
            end
            assign bytes_q[g*BYTE_W +: BYTE_W] = q;
        end
    endgenerate
endmodule

// File: rtl/alarm_rate_decode.sv
// Module: turns the five scattered rate bits into a rate and a mask of the fields to compare.
// Codes outside the six defined ones fall back to the every-second rate.
module alarm_rate_decode
    import alarm_pkg::*;
(
    input  logic [BUS_W-1:0]  bytes_q,
    output rate_e             rate,
    output logic [NFIELD-1:0] need
);
    logic [4:0] code;   // {bit5, bit4, bit3, bit2, bit1}

    // gather the rate bits from their home bytes
    always_comb begin
        code = {bytes_q[F_DAY*BYTE_W + 6],
                bytes_q[F_DAY*BYTE_W + 7],
                bytes_q[F_HOUR*BYTE_W + 7],
                bytes_q[F_MIN*BYTE_W + 7],
                bytes_q[F_SEC*BYTE_W + 7]};
    end

    // map the code to a rate and the set of fields that must match
    always_comb begin
        case (code)
            5'b11110: begin rate = RATE_MIN;   need = 5'b00001; end
            5'b11100: begin rate = RATE_HOUR;  need = 5'b00011; end
            5'b11000: begin rate = RATE_DAY;   need = 5'b00111; end
            5'b10000: begin rate = RATE_MONTH; need = 5'b01111; end
            5'b00000: begin rate = RATE_YEAR;  need = 5'b11111; end
            default:  begin rate = RATE_SEC;   need = 5'b00000; end
        endcase
    end
endmodule

// File: rtl/alarm_field_cmp.sv
// Module: compares every BCD field of the current time with its alarm field under the field mask.
// The match is qualified by the set of fields the rate requires.
module alarm_field_cmp
    import alarm_pkg::*;
(
    input  logic [BUS_W-1:0]  now_bus,
    input  logic [BUS_W-1:0]  bytes_q,
    input  logic [NFIELD-1:0] need,
    output logic              match
);
    logic [NFIELD-1:0] eq;

    genvar g;
    generate
        for (g = 0; g < NFIELD; g++) begin : g_cmp
            localparam logic [BYTE_W-1:0] M = FIELD_MASKS[g*BYTE_W +: BYTE_W];
            // compare only the significant BCD bits of this field
            assign eq[g] = ((now_bus[g*BYTE_W +: BYTE_W] ^ bytes_q[g*BYTE_W +: BYTE_W]) & M) == '0;
        end
    endgenerate

    // every required field must be equal
    assign match = &(eq | ~need);
endmodule

// File: rtl/alarm_match_unit.sv
// Module: top of the alarm comparator. Holds the sticky flag and the open-drain request enable.
// Assumes sec_tick is a one-cycle pulse while the cur_* fields are stable.
module alarm_match_unit
    import alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [BYTE_W-1:0] cur_month,
    input  logic [BYTE_W-1:0] cur_day,
    input  logic [BYTE_W-1:0] cur_hour,
    input  logic [BYTE_W-1:0] cur_min,
    input  logic [BYTE_W-1:0] cur_sec,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              flag_rd,
    input  logic              backup,
    input  logic              pwr_up,
    output logic              alarm_flag,
    output logic              irq_pull,
    output logic              irq_n
);
    logic [BUS_W-1:0]  bytes_q;
    logic [BUS_W-1:0]  now_bus;
    logic [NFIELD-1:0] need;
    rate_e             rate;
    logic              match;
    logic              hit;
    logic              ie;
    logic              be;
    logic              irq_ok;
    logic              flag_q;
    logic              pull_q;

    assign now_bus = {cur_month, cur_day, cur_hour, cur_min, cur_sec};

    alarm_bytes u_bytes (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pwr_up(pwr_up), .bytes_q(bytes_q)
    );

    alarm_rate_decode u_rate (
        .bytes_q(bytes_q), .rate(rate), .need(need)
    );

    alarm_field_cmp u_cmp (
        .now_bus(now_bus), .bytes_q(bytes_q), .need(need), .match(match)
    );

    // qualify the match with the strobe and pick the enables gating the request
    always_comb begin
        hit    = sec_tick & match;
        ie     = bytes_q[F_MONTH*BYTE_W + 7];
        be     = bytes_q[F_MONTH*BYTE_W + 5];
        irq_ok = ie & (~backup | be);
    end

    // sticky flag and request; a new event outranks a same-cycle flags read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            pull_q <= 1'b0;
        end else begin
            if (hit)          flag_q <= 1'b1;
            else if (flag_rd) flag_q <= 1'b0;
            if (hit && irq_ok) pull_q <= 1'b1;
            else if (flag_rd)  pull_q <= 1'b0;
        end
    end

    assign alarm_flag = flag_q;
    assign irq_pull   = pull_q;
    assign irq_n      = ~pull_q;
endmodule

// File: rtl/alarm_match_unit_chk.sv
// Module: property checker bound to alarm_match_unit.
module alarm_match_unit_chk
    import alarm_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  sec_tick,
    input logic  flag_rd,
    input logic  backup,
    input logic  pwr_up,
    input logic  hit,
    input logic  ie,
    input logic  be,
    input rate_e rate,
    input logic  alarm_flag,
    input logic  irq_pull
);
    // R7: the flag can only rise after a strobe
    assert_flag_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(sec_tick));

    // R8: a request is never held without the flag
    assert_pull_with_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull |-> alarm_flag);

    // R9: a request raised in backup mode needs both enables
    assert_backup_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pull) |-> ($past(ie) && (!$past(backup) || $past(be))));

    // R10: a lone flags read clears flag and request
    assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !hit) |=> (!alarm_flag && !irq_pull));

    // R11: a power-up event leaves both enables cleared
    assert_pwrup_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_up |=> (!ie && !be));

    // R6: the every-second rate fires on every strobe
    assert_every_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && rate == RATE_SEC) |=> alarm_flag);
endmodule

bind alarm_match_unit alarm_match_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .flag_rd(flag_rd),
    .backup(backup), .pwr_up(pwr_up), .hit(hit), .ie(ie), .be(be),
    .rate(rate), .alarm_flag(alarm_flag), .irq_pull(irq_pull)
);

// File: tb/tb_alarm_match_unit.sv
`timescale 1ns/1ps
module tb_alarm_match_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [7:0] cur_month = 8'h01, cur_day = 8'h01, cur_hour = 8'h00, cur_min = 8'h00, cur_sec = 8'h00;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       flag_rd = 1'b0, backup = 1'b0, pwr_up = 1'b0;
    logic       alarm_flag, irq_pull, irq_n;
    int         n_checks = 0, n_fails = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    alarm_match_unit dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cur_month(cur_month), .cur_day(cur_day), .cur_hour(cur_hour),
        .cur_min(cur_min), .cur_sec(cur_sec),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .flag_rd(flag_rd), .backup(backup), .pwr_up(pwr_up),
        .alarm_flag(alarm_flag), .irq_pull(irq_pull), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // code bits {5,4,3,2,1}, BCD fields, enables
    task automatic set_alarm(input logic [4:0] c, input logic [7:0] mo, dy, hr, mi, se,
                             input logic ie_b, be_b);
        wr(3'd0, {c[0], se[6:0]});
        wr(3'd1, {c[1], mi[6:0]});
        wr(3'd2, {c[2], 1'b0, hr[5:0]});
        wr(3'd3, {c[3], c[4], dy[5:0]});
        wr(3'd4, {ie_b, 1'b0, be_b, mo[4:0]});
    endtask

    task automatic tick(input logic [7:0] mo, dy, hr, mi, se);
        cur_month = mo; cur_day = dy; cur_hour = hr; cur_min = mi; cur_sec = se;
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic rd_flags();
        flag_rd = 1'b1;
        @(negedge clk);
        flag_rd = 1'b0;
    endtask

    // expects flag/irq after one strobe, then clears
    task automatic expect_tick(input string req, input logic [7:0] mo, dy, hr, mi, se,
                               input logic f, input logic p);
        tick(mo, dy, hr, mi, se);
        chk(req, {7'd0, alarm_flag}, {7'd0, f});
        chk(req, {7'd0, irq_n}, {7'd0, ~p});
        rd_flags();
    endtask

    task automatic t_reset();
        chk("R1 flag", {7'd0, alarm_flag}, 8'd0);
        chk("R1 pull", {7'd0, irq_pull}, 8'd0);
        chk("R1 irq_n", {7'd0, irq_n}, 8'd1);
        // all-zero bytes: yearly rate, month 00 never matches month 01
        expect_tick("R1 yearly default", 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_rates();
        set_alarm(5'b11111, 8'h05, 8'h10, 8'h12, 8'h34, 8'h56, 1'b1, 1'b0);
        expect_tick("R2 every second", 8'h09, 8'h21, 8'h03, 8'h07, 8'h11, 1'b1, 1'b1);
        set_alarm(5'b11110, 8'h05, 8'h10, 8'h12, 8'h34, 8'h30, 1'b1, 1'b0);
        expect_tick("R3 minute miss", 8'h09, 8'h21, 8'h03, 8'h07, 8'h29, 1'b0, 1'b0);
        expect_tick("R3 minute hit", 8'h09, 8'h21, 8'h03, 8'h07, 8'h30, 1'b1, 1'b1);
        set_alarm(5'b11100, 8'h05, 8'h10, 8'h12, 8'h15, 8'h30, 1'b1, 1'b0);
        expect_tick("R4 hour miss", 8'h09, 8'h21, 8'h03, 8'h16, 8'h30, 1'b0, 1'b0);
        expect_tick("R4 hour hit", 8'h09, 8'h21, 8'h03, 8'h15, 8'h30, 1'b1, 1'b1);
        set_alarm(5'b11000, 8'h05, 8'h10, 8'h23, 8'h15, 8'h30, 1'b1, 1'b0);
        expect_tick("R4 day miss", 8'h09, 8'h21, 8'h22, 8'h15, 8'h30, 1'b0, 1'b0);
        expect_tick("R4 day hit", 8'h09, 8'h21, 8'h23, 8'h15, 8'h30, 1'b1, 1'b1);
        set_alarm(5'b10000, 8'h05, 8'h31, 8'h23, 8'h15, 8'h30, 1'b1, 1'b0);
        expect_tick("R5 month miss", 8'h09, 8'h30, 8'h23, 8'h15, 8'h30, 1'b0, 1'b0);
        expect_tick("R5 month hit", 8'h09, 8'h31, 8'h23, 8'h15, 8'h30, 1'b1, 1'b1);
        set_alarm(5'b00000, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 1'b1, 1'b0);
        expect_tick("R5 year miss", 8'h11, 8'h31, 8'h23, 8'h59, 8'h59, 1'b0, 1'b0);
        expect_tick("R5 year hit", 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 1'b1, 1'b1);
        set_alarm(5'b10101, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 1'b1, 1'b0);
        expect_tick("R6 invalid code", 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 1'b1, 1'b1);
        set_alarm(5'b01111, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 1'b1, 1'b0);
        expect_tick("R6 invalid code 01111", 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 1'b1, 1'b1);
    endtask

    task automatic t_strobe();
        set_alarm(5'b00000, 8'h06, 8'h15, 8'h10, 8'h20, 8'h30, 1'b1, 1'b0);
        cur_month = 8'h06; cur_day = 8'h15; cur_hour = 8'h10; cur_min = 8'h20; cur_sec = 8'h30;
        repeat (4) @(negedge clk);
        chk("R7 no strobe no event", {7'd0, alarm_flag}, 8'd0);
        tick(8'h06, 8'h15, 8'h10, 8'h20, 8'h30);
        chk("R7 event next edge", {7'd0, alarm_flag}, 8'd1);
        rd_flags();
    endtask

    task automatic t_enables();
        set_alarm(5'b11111, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
        expect_tick("R8 enable off", 8'h01, 8'h01, 8'h00, 8'h00, 8'h01, 1'b1, 1'b0);
        backup = 1'b1;
        set_alarm(5'b11111, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
        expect_tick("R9 backup without be", 8'h01, 8'h01, 8'h00, 8'h00, 8'h02, 1'b1, 1'b0);
        set_alarm(5'b11111, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1);
        expect_tick("R9 backup both set", 8'h01, 8'h01, 8'h00, 8'h00, 8'h03, 1'b1, 1'b1);
        backup = 1'b0;
        set_alarm(5'b11111, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
        expect_tick("R8 normal mode ie only", 8'h01, 8'h01, 8'h00, 8'h00, 8'h04, 1'b1, 1'b1);
    endtask

    task automatic t_read();
        tick(8'h01, 8'h01, 8'h00, 8'h00, 8'h05);
        flag_rd = 1'b1; sec_tick = 1'b1;
        @(negedge clk);
        flag_rd = 1'b0; sec_tick = 1'b0;
        chk("R10 event beats read flag", {7'd0, alarm_flag}, 8'd1);
        chk("R10 event beats read irq", {7'd0, irq_n}, 8'd0);
        rd_flags();
        chk("R10 read clears flag", {7'd0, alarm_flag}, 8'd0);
        chk("R10 read releases irq", {7'd0, irq_pull}, 8'd0);
    endtask

    task automatic t_pwrup();
        pwr_up = 1'b1;
        @(negedge clk);
        pwr_up = 1'b0;
        expect_tick("R11 power-up clears enables", 8'h01, 8'h01, 8'h00, 8'h00, 8'h06, 1'b1, 1'b0);
        pwr_up = 1'b1; wr_en = 1'b1; wr_sel = 3'd4; wr_data = 8'hA1;
        @(negedge clk);
        pwr_up = 1'b0; wr_en = 1'b0;
        expect_tick("R11 power-up beats write", 8'h01, 8'h01, 8'h00, 8'h00, 8'h07, 1'b1, 1'b0);
        // the month value itself survives: yearly rate, month 01 must still match
        set_alarm(5'b00000, 8'h01, 8'h01, 8'h00, 8'h00, 8'h08, 1'b1, 1'b0);
        pwr_up = 1'b1;
        @(negedge clk);
        pwr_up = 1'b0;
        expect_tick("R11 month kept", 8'h01, 8'h01, 8'h00, 8'h00, 8'h08, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rates();
        t_strobe();
        t_enables();
        t_read();
        t_pwrup();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule